// File: doc/BRIEF.md
# Supply Rail Fault Supervisor

This block watches five supply rails that depend on one another. They are named, from upstream to downstream, MAIN, SYS, IO, CORE and AUX. For each rail it receives a one-cycle fault pulse, which reports an under-voltage or over-current event. It also receives two comparator levels: low supply voltage, and a die over-temperature warning. The block drives one enable per rail, three system enables (signal path, driver stage and processor-alive) and a single active-high interrupt line.

When a rail faults, the block turns off that rail and every rail downstream of it, and records one or more fault flags. Software reads and clears the flags through a small register port. Writing a 1 to a flag clears it; writing a 0 has no effect. When the last flag is cleared, the rails that were turned off come back one at a time, in dependency order, with a fixed number of cycles between steps. The two comparator events each set a live status bit and a sticky latch. The latches feed the interrupt line, and the over-temperature latch reaches it only through an enable bit.

Top module: `pfs_supervisor`

## Requirements
- R1: A synchronous reset turns off all outputs and clears all register bits. The power-up sequence then starts. Rail k (0=MAIN, 1=SYS, 2=IO, 3=CORE, 4=AUX) turns on exactly STEP_CYCLES cycles after the previous step, so rails only ever turn on in the order 0,1,2,3,4.
- R2: A MAIN fault pulse turns off all five rails in the next cycle and sets fault flag bit 0 (register address 0, bits [4:0] are the flags of rails 0..4).
- R3: A SYS fault pulse turns off rails 1..4, leaves rail 0 on, and sets flag bit 1.
- R4: A fault pulse on any of IO, CORE or AUX turns off rails 2..4 and sets flag bits 2, 3 and 4 together.
- R5: The signal, driver and processor-alive enables are 0 from the cycle after any fault pulse, and stay 0 while any flag is set. They become 1 one cycle after the last rail turns on, provided no fault is present.
- R6: Writing 1 to a flag bit clears that bit. Restart begins only when all flags are clear. It starts at the lowest rail that is off and continues in order, one rail every STEP_CYCLES cycles.
- R7: A fault pulse during a restart stops the sequence, applies that fault's shutdown and flags again, and waits for a new clear.
- R8: Register address 1 holds the low-voltage status: bit 0 is the live comparator value and bit 1 is the sticky latch. The latch stays set after the comparator returns to 0. Writing 1 to bit 1 clears it and drops the interrupt, which is not maskable.
- R9: Address 1 also holds the over-temperature status: bit 2 is live and bit 3 is the sticky latch. Address 2 bit 0 is the over-temperature interrupt enable (read/write). The interrupt is raised for this latch only when the enable is 1. Writing 1 to bit 3 clears the latch.
- R10: If a set event and a write-one-to-clear reach the same flag or latch in the same cycle, the set event wins.
- R11: Writing 0 to any flag or latch bit leaves it and the rail enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_fault_p | input | 5 | One-cycle fault pulse per rail, bit k = rail k |
| vlow_in | input | 1 | Low supply voltage comparator level |
| hot_in | input | 1 | Over-temperature warning comparator level |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the address |
| rail_en | output | 5 | Rail enables, bit k = rail k |
| sig_en | output | 1 | Signal-path enable |
| drv_en | output | 1 | Driver-stage enable |
| mcu_alive | output | 1 | Processor-alive enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a fault that arrives in the middle of a restart, while some downstream rails are still waiting for their turn. The bench creates a MAIN fault and clears it. It then polls the rail enables until IO has just come up, and sends a CORE pulse in the next cycle. This shows that the sequence stops and restarts from IO rather than from MAIN. A second hard case is a set event and its clear arriving in the same cycle. The bench drives the fault pulse or the held comparator level on the same edge as the clearing write.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int unsigned NUM_RAILS  = 5;
  localparam int unsigned GROUP_BASE = 2;
  localparam int unsigned RIDX_W     = $clog2(NUM_RAILS + 1);

  localparam logic [1:0] ADDR_FLAGS  = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  // lowest rail switched off by a fault on rail r
  function automatic logic [RIDX_W-1:0] first_killed(input int unsigned r);
    return (r < GROUP_BASE) ? RIDX_W'(r) : RIDX_W'(GROUP_BASE);
  endfunction

  // flag bits raised by a fault on rail r
  function automatic logic [NUM_RAILS-1:0] flag_group(input int unsigned r);
    logic [NUM_RAILS-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_RAILS; i++) begin
      if (r < GROUP_BASE) m[i] = (i == r);
      else                m[i] = (i >= GROUP_BASE);
    end
    return m;
  endfunction
endpackage

// File: rtl/pfs_fault_map.sv
module pfs_fault_map
  import pfs_pkg::*;
(
  input  logic [NUM_RAILS-1:0] pulse,
  output logic [NUM_RAILS-1:0] set_mask,
  output logic [RIDX_W-1:0]    kill_start
);
  logic [NUM_RAILS-1:0] contrib [NUM_RAILS];

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    assign contrib[r] = pulse[r] ? flag_group(r) : '0;
  end

  always_comb begin
    set_mask = '0;
    for (int r = 0; r < NUM_RAILS; r++) set_mask = set_mask | contrib[r];
  end

  // first_killed is non-decreasing in r, so scanning downward leaves the minimum
  always_comb begin
    kill_start = RIDX_W'(NUM_RAILS);
    for (int r = NUM_RAILS - 1; r >= 0; r--) begin
      if (pulse[r]) kill_start = first_killed(r);
    end
  end
endmodule

// File: rtl/pfs_w1c_bank.sv
module pfs_w1c_bank #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_ev,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                        q[i] <= 1'b0;
      else if (set_ev[i])             q[i] <= 1'b1;
      else if (clr_stb && clr_bits[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pfs_sequencer.sv
module pfs_sequencer
  import pfs_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fault_any,
  input  logic [RIDX_W-1:0]    kill_start,
  output logic [NUM_RAILS-1:0] rail_q,
  output logic                 all_up
);
  localparam int unsigned CNT_W = (STEP_CYCLES < 2) ? 1 : $clog2(STEP_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

  logic [RIDX_W-1:0]    idx_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_RAILS-1:0] keep_mask;
  logic [NUM_RAILS-1:0] next_bit;

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_mask
    assign keep_mask[i] = (RIDX_W'(i) < kill_start);
    assign next_bit[i]  = (idx_q == RIDX_W'(i));
  end

  assign all_up = (idx_q == RIDX_W'(NUM_RAILS));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      rail_q <= '0;
    end else if (fault_any) begin
      cnt_q  <= '0;
      rail_q <= rail_q & keep_mask;
      if (kill_start < idx_q) idx_q <= kill_start;
    end else if (!all_up) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        idx_q  <= idx_q + 1'b1;
        rail_q <= rail_q | next_bit;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 16,
  parameter int unsigned DATA_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [4:0]           rail_fault_p,
  input  logic                 vlow_in,
  input  logic                 hot_in,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [4:0]           rail_en,
  output logic                 sig_en,
  output logic                 drv_en,
  output logic                 mcu_alive,
  output logic                 irq
);
  logic [NUM_RAILS-1:0] flag_set, flag_q;
  logic [RIDX_W-1:0]    kill_start;
  logic                 fault_any, all_up;
  logic [1:0]           lat_q;
  logic                 vlow_live_q, hot_live_q, hot_ie_q;
  logic                 sys_q, irq_q;
  logic                 unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:NUM_RAILS];

  pfs_fault_map u_map (
    .pulse      (rail_fault_p),
    .set_mask   (flag_set),
    .kill_start (kill_start)
  );

  pfs_w1c_bank #(.WIDTH(NUM_RAILS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_ev   (flag_set),
    .clr_stb  (reg_wr && reg_addr == ADDR_FLAGS),
    .clr_bits (reg_wdata[NUM_RAILS-1:0]),
    .q        (flag_q)
  );

  // lat_q[0]: low-voltage latch, lat_q[1]: over-temperature latch
  pfs_w1c_bank #(.WIDTH(2)) u_latches (
    .clk      (clk),
    .rst      (rst),
    .set_ev   ({hot_in, vlow_in}),
    .clr_stb  (reg_wr && reg_addr == ADDR_STATUS),
    .clr_bits ({reg_wdata[3], reg_wdata[1]}),
    .q        (lat_q)
  );

  assign fault_any = (|flag_q) | (|rail_fault_p);

  pfs_sequencer #(.STEP_CYCLES(STEP_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .fault_any  (fault_any),
    .kill_start (kill_start),
    .rail_q     (rail_en),
    .all_up     (all_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vlow_live_q <= 1'b0;
      hot_live_q  <= 1'b0;
      hot_ie_q    <= 1'b0;
      sys_q       <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      vlow_live_q <= vlow_in;
      hot_live_q  <= hot_in;
      if (reg_wr && reg_addr == ADDR_CTRL) hot_ie_q <= reg_wdata[0];
      sys_q <= all_up && !fault_any;
      irq_q <= lat_q[0] | (lat_q[1] & hot_ie_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        ADDR_FLAGS:  reg_rdata <= DATA_W'(flag_q);
        ADDR_STATUS: reg_rdata <= DATA_W'({lat_q[1], hot_live_q, lat_q[0], vlow_live_q});
        ADDR_CTRL:   reg_rdata <= DATA_W'(hot_ie_q);
        default:     reg_rdata <= '0;
      endcase
    end
  end

  assign sig_en    = sys_q;
  assign drv_en    = sys_q;
  assign mcu_alive = sys_q;
  assign irq       = irq_q;
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] rail_fault_p,
  input logic       vlow_in,
  input logic [4:0] rail_en,
  input logic       sig_en,
  input logic       drv_en,
  input logic       mcu_alive,
  input logic       irq
);
  p_prefix_r1: assert property (@(posedge clk) disable iff (rst)
    (rail_en & (rail_en + 5'd1)) == 5'd0);
  p_one_step_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(rail_en) <= $countones($past(rail_en)) + 1);
  p_main_kill_r2: assert property (@(posedge clk) disable iff (rst)
    rail_fault_p[0] |=> rail_en == 5'd0);
  p_sys_kill_r3: assert property (@(posedge clk) disable iff (rst)
    rail_fault_p[1] |=> rail_en[4:1] == 4'd0);
  p_group_kill_r4: assert property (@(posedge clk) disable iff (rst)
    (|rail_fault_p[4:2]) |=> rail_en[4:2] == 3'd0);
  p_sys_off_r5: assert property (@(posedge clk) disable iff (rst)
    (|rail_fault_p) |=> (!sig_en && !drv_en && !mcu_alive));
  p_sys_needs_rails_r5: assert property (@(posedge clk) disable iff (rst)
    sig_en |-> rail_en == 5'h1F);
  p_vlow_irq_r8: assert property (@(posedge clk) disable iff (rst)
    vlow_in |-> ##2 irq);
endmodule

bind pfs_supervisor pfs_supervisor_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .rail_fault_p (rail_fault_p),
  .vlow_in      (vlow_in),
  .rail_en      (rail_en),
  .sig_en       (sig_en),
  .drv_en       (drv_en),
  .mcu_alive    (mcu_alive),
  .irq          (irq)
);

// File: tb/pfs_supervisor_test.sv
`timescale 1ns/1ps
module pfs_supervisor_test;
  localparam int S = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rail_fault_p = '0;
  logic       vlow_in = 1'b0, hot_in = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [4:0] rail_en;
  logic       sig_en, drv_en, mcu_alive, irq;

  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  pfs_supervisor #(.STEP_CYCLES(S)) uut (
    .clk(clk), .rst(rst), .rail_fault_p(rail_fault_p), .vlow_in(vlow_in),
    .hot_in(hot_in), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rail_en(rail_en), .sig_en(sig_en), .drv_en(drv_en),
    .mcu_alive(mcu_alive), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] m);
    rail_fault_p = m;
    @(negedge clk);
    rail_fault_p = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_sys(input string req, input logic exp);
    chk(req, {sig_en, drv_en, mcu_alive}, {3{exp}});
  endtask

  // expects rails start..4 to come up one by one, S cycles apart, then the system enables
  task automatic expect_seq(input int start, input string req);
    logic [4:0] prev;
    prev = rail_en;
    for (int k = start; k < 5; k++) begin
      int n;
      n = 0;
      while (rail_en == prev && n <= 4 * S) begin
        @(negedge clk);
        n++;
      end
      chk({req, " rail order"}, rail_en, prev | (5'd1 << k));
      chk({req, " step spacing"}, n, S);
      prev = rail_en;
    end
    chk_sys({req, " system enables before"}, 1'b0);
    @(negedge clk);
    chk_sys("R5 system enables after full power-up", 1'b1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    idle(4);
    chk("R1 rails off in reset", rail_en, 5'd0);
    chk_sys("R1 system enables off in reset", 1'b0);
    chk("R1 irq off in reset", irq, 1'b0);
    rst = 1'b0;
    expect_seq(0, "R1");
    rd(2'd0, d); chk("R1 flags zero", d, 8'h00);
    rd(2'd1, d); chk("R1 status zero", d, 8'h00);
    rd(2'd2, d); chk("R1 ctrl zero", d, 8'h00);
  endtask

  task automatic t_main_fault;
    logic [7:0] d;
    pulse(5'b00001);
    chk("R2 main fault kills all rails", rail_en, 5'd0);
    chk_sys("R5 system enables drop on fault", 1'b0);
    rd(2'd0, d); chk("R2 main flag", d, 8'h01);
    idle(3 * S);
    chk("R6 no restart while flag set", rail_en, 5'd0);
    chk_sys("R5 system enables held off", 1'b0);
    wr(2'd0, 8'h01);
    expect_seq(0, "R6 restart after main clear");
  endtask

  task automatic t_sys_fault;
    logic [7:0] d;
    pulse(5'b00010);
    chk("R3 sys fault keeps rail 0 only", rail_en, 5'b00001);
    rd(2'd0, d); chk("R3 sys flag", d, 8'h02);
    wr(2'd0, 8'h02);
    expect_seq(1, "R6 restart from SYS");
  endtask

  task automatic t_group_fault;
    logic [7:0] d;
    pulse(5'b01000);
    chk("R4 group fault keeps rails 0-1", rail_en, 5'b00011);
    rd(2'd0, d); chk("R4 group flags together", d, 8'h1C);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R6 partial clear", d, 8'h18);
    idle(3 * S);
    chk("R6 no restart with flags left", rail_en, 5'b00011);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R11 zero write keeps flags", d, 8'h18);
    chk("R11 zero write keeps rails", rail_en, 5'b00011);
    wr(2'd0, 8'h18);
    expect_seq(2, "R6 restart from IO");
  endtask

  task automatic t_abort;
    logic [7:0] d;
    int n;
    pulse(5'b00001);
    wr(2'd0, 8'h01);
    n = 0;
    while (rail_en != 5'b00111 && n < 10 * S) begin
      @(negedge clk);
      n++;
    end
    chk("R7 reached IO during restart", rail_en, 5'b00111);
    pulse(5'b01000);
    chk("R7 abort drops IO", rail_en, 5'b00011);
    idle(2 * S);
    chk("R7 sequence halted", rail_en, 5'b00011);
    rd(2'd0, d); chk("R7 group flags", d, 8'h1C);
    wr(2'd0, 8'h1C);
    expect_seq(2, "R7 resume from IO");
  endtask

  task automatic t_vlow;
    logic [7:0] d;
    vlow_in = 1'b1;
    idle(3);
    rd(2'd1, d); chk("R8 live and latch set", d[1:0], 2'b11);
    chk("R8 irq raised", irq, 1'b1);
    vlow_in = 1'b0;
    idle(2);
    rd(2'd1, d); chk("R8 live follows, latch sticky", d[1:0], 2'b10);
    wr(2'd1, 8'h00);
    idle(2);
    rd(2'd1, d); chk("R11 zero write keeps latch", d[1:0], 2'b10);
    chk("R11 irq kept", irq, 1'b1);
    wr(2'd1, 8'h02);
    idle(2);
    rd(2'd1, d); chk("R8 latch cleared", d[1:0], 2'b00);
    chk("R8 irq dropped", irq, 1'b0);
  endtask

  task automatic t_hot;
    logic [7:0] d;
    hot_in = 1'b1;
    idle(3);
    rd(2'd1, d); chk("R9 hot live and latch", d[3:2], 2'b11);
    chk("R9 masked irq stays low", irq, 1'b0);
    hot_in = 1'b0;
    idle(2);
    rd(2'd1, d); chk("R9 hot latch sticky", d[3:2], 2'b10);
    wr(2'd2, 8'h01);
    idle(2);
    rd(2'd2, d); chk("R9 enable readback", d, 8'h01);
    chk("R9 enabled irq raised", irq, 1'b1);
    wr(2'd1, 8'h08);
    idle(2);
    rd(2'd1, d); chk("R9 hot latch cleared", d[3:2], 2'b00);
    chk("R9 irq dropped", irq, 1'b0);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    hot_in = 1'b1;
    idle(2);
    wr(2'd1, 8'h08);
    rd(2'd1, d); chk("R10 held event beats clear", d[3], 1'b1);
    hot_in = 1'b0;
    wr(2'd1, 8'h08);
    idle(2);
    chk("R10 irq low after clear", irq, 1'b0);
    rail_fault_p = 5'b00001;
    reg_addr = 2'd0; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(negedge clk);
    rail_fault_p = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, d); chk("R10 fault pulse beats clear", d, 8'h01);
    chk("R10 rails off", rail_en, 5'd0);
    wr(2'd0, 8'h01);
    expect_seq(0, "R10 restart");
  endtask

  initial begin
    t_reset();
    t_main_fault();
    t_sys_fault();
    t_group_fault();
    t_abort();
    t_vlow();
    t_hot();
    t_set_wins();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule